// File: doc/BRIEF.md
# Keyed Double-Ended Configuration Stack

This block holds a small set of 16-bit configuration entries, each identified by a 5-bit key in its low bits. The entries are always packed from index 0 upward, and the first all-zero slot ends the occupied region. Software changes the set by writing to one of two register addresses. One address acts on the high end ("top") and the other acts on the low end ("bottom"). The block works like a deque whose entries can also be found by key.

A write word is cut into 16-bit fields, and the block applies them one per clock, starting with the least significant field. A field whose key already sits in the set replaces that entry in place. A field with a new key is pushed at the selected end. An all-zero field pops from the selected end. When a push lands on a full set, the entry at the opposite end is dropped. Every field yields an evicted or popped value, and these values are gathered into a result word that is presented together with a one-cycle completion pulse.

Top module: `kcfg_deque`

## Requirements
- R1: After reset every entry reads zero, count_o is 0, full_o is 0 and busy_o is 0. At all times, entries below count_o are nonzero and entries at or above count_o are zero.
- R2: When a field has a nonzero key (bits [4:0]) equal to the key of an occupied entry, that entry is replaced by the whole field. No entry moves, the count does not change, and the field's result is zero. Occupied nonzero keys stay unique.
- R3: A zero field at the top end clears the highest occupied entry and reports its value. On an empty set it changes nothing and reports zero.
- R4: A zero field at the bottom end reports entry 0, moves every entry down by one index and clears the freed highest slot.
- R5: A top push with free room writes the field at index count_o and increments the count.
- R6: A top push into a full set reports the old entry 0, moves the other entries down by one and places the field at index DEPTH-1. The count stays at DEPTH.
- R7: A bottom push moves the entries up by one and writes the field at index 0. If the set was full, the old entry DEPTH-1 is lost and is reported. Otherwise the count increments and the result is zero.
- R8: A write to address 0x4c0 selects top operations, and a write to 0x4c1 selects bottom operations. A write to any other address has no effect.
- R9: Fields are taken from the least significant one upward (XLEN/16 of them). Processing stops at the first zero field at position 1 or above, so only field 0 can pop. The result of field i appears at bits [16*i+15:16*i] of result_o, and fields that are not processed give zero.
- R10: A write is accepted only while busy_o is low, and writes made while busy are ignored. After acceptance, busy_o is high from the next cycle. Exactly one field position is examined per cycle. done_o pulses for one cycle N cycles after busy_o rises, where N is the number of fields examined including a stopping zero field. busy_o falls in the same cycle.
- R11: count_o gives the number of occupied entries. full_o is high exactly when count_o equals DEPTH (16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write address |
| wr_data_i | input | XLEN (64) | Write word, split into 16-bit fields |
| busy_o | output | 1 | A write is being processed |
| done_o | output | 1 | One-cycle pulse: result_o is valid |
| result_o | output | XLEN (64) | Evicted or popped values packed per field |
| entries_o | output | DEPTH*16 (256) | All entries, entry i at bits [16*i+15:16*i] |
| count_o | output | 5 | Number of occupied entries |
| full_o | output | 1 | All DEPTH slots occupied |

## Verification
Key matching and overflow eviction can hit the same field. This happens when a set is full and a field's key matches an occupied entry. The bench fills the set to DEPTH, then writes a matching key at both ends and expects an in-place rewrite with a zero result and no shift. A second case is a single write word whose later field repeats the key pushed by an earlier field. The second field must become an update rather than a second push. Both cases are directed, and the constrained-random traffic uses a narrow key range so that they also recur there. Each one is judged against the bench's own model of entries, count and result.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_UPDATE   = 3'd1,
    OP_POP_TOP  = 3'd2,
    OP_POP_BOT  = 3'd3,
    OP_PUSH_TOP = 3'd4,
    OP_PUSH_BOT = 3'd5
  } kcfg_op_e;
endpackage

// File: rtl/kcfg_match.sv
module kcfg_match #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int KEY_W   = 5,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DEPTH-1:0][ENTRY_W-1:0]   ent_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic [KEY_W-1:0]                key_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                hit_idx_o
);
  logic             key_ok;
  logic [DEPTH-1:0] hit_vec;

  assign key_ok = (key_i != '0);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    assign hit_vec[gi] = key_ok && (CNT_W'(gi) < cnt_i) &&
                         (ent_i[gi][KEY_W-1:0] == key_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;

  // R2
  unique_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/kcfg_store.sv
module kcfg_store
  import kcfg_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 16,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  kcfg_op_e                       op_i,
  input  logic [ENTRY_W-1:0]             field_i,
  input  logic [IDX_W-1:0]               hit_idx_i,
  output logic [DEPTH-1:0][ENTRY_W-1:0]  ent_o,
  output logic [CNT_W-1:0]               cnt_o,
  output logic                           full_o,
  output logic [ENTRY_W-1:0]             evict_o
);
  logic [DEPTH-1:0][ENTRY_W-1:0] ent_q, ent_d;
  logic [CNT_W-1:0]              cnt_q, cnt_d;
  logic                          full;
  logic                          empty;
  logic [IDX_W-1:0]              last_idx;
  logic                          upd_en;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign last_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign upd_en   = (op_i != OP_IDLE);

  always_comb begin
    ent_d   = ent_q;
    cnt_d   = cnt_q;
    evict_o = '0;
    case (op_i)
      OP_UPDATE: begin
        ent_d[hit_idx_i] = field_i;
      end
      OP_POP_TOP: begin
        if (!empty) begin
          evict_o         = ent_q[last_idx];
          ent_d[last_idx] = '0;
          cnt_d           = cnt_q - CNT_W'(1);
        end
      end
      OP_POP_BOT: begin
        evict_o = ent_q[0];
        for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
        ent_d[DEPTH-1] = '0;
        if (!empty) cnt_d = cnt_q - CNT_W'(1);
      end
      OP_PUSH_TOP: begin
        if (full) begin
          evict_o = ent_q[0];
          for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
          ent_d[DEPTH-1] = field_i;
        end else begin
          ent_d[IDX_W'(cnt_q)] = field_i;
          cnt_d                = cnt_q + CNT_W'(1);
        end
      end
      OP_PUSH_BOT: begin
        if (full) evict_o = ent_q[DEPTH-1];
        else      cnt_d   = cnt_q + CNT_W'(1);
        for (int i = DEPTH - 1; i > 0; i--) ent_d[i] = ent_q[i-1];
        ent_d[0] = field_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      ent_q <= ent_d;
      cnt_q <= cnt_d;
    end
  end

  assign ent_o  = ent_q;
  assign cnt_o  = cnt_q;
  assign full_o = full;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_pack_chk
    // R1
    packed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_q[gi] != '0) == (CNT_W'(gi) < cnt_q));
  end

  // R2
  update_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_UPDATE) |=> $stable(cnt_q));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP_TOP && empty) |=> (cnt_q == '0 && $stable(ent_q)));

  // R6
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH_TOP && full) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/kcfg_seq.sv
module kcfg_seq #(
  parameter int          XLEN     = 64,
  parameter int          ENTRY_W  = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] TOP_ADDR = 12'h4c0,
  parameter logic [11:0] BOT_ADDR = 12'h4c1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [XLEN-1:0]    wr_data_i,
  input  logic [ENTRY_W-1:0] evict_i,
  output logic               apply_o,
  output logic               top_o,
  output logic [ENTRY_W-1:0] field_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [XLEN-1:0]    result_o
);
  localparam int NF     = XLEN / ENTRY_W;
  localparam int FIDX_W = (NF > 1) ? $clog2(NF) : 1;

  logic [XLEN-1:0]   word_q, word_d;
  logic [XLEN-1:0]   res_q, res_d;
  logic [FIDX_W-1:0] idx_q, idx_d;
  logic              top_q, top_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              hit_top, hit_bot, accept, stop, last;

  assign hit_top = (wr_addr_i == ADDR_W'(TOP_ADDR));
  assign hit_bot = (wr_addr_i == ADDR_W'(BOT_ADDR));
  assign accept  = wr_en_i && !busy_q && (hit_top || hit_bot);
  assign field_o = word_q[idx_q*ENTRY_W +: ENTRY_W];
  assign stop    = (idx_q != '0) && (field_o == '0);
  assign last    = (idx_q == FIDX_W'(NF - 1));
  assign apply_o = busy_q && !stop;

  always_comb begin
    word_d = word_q;
    res_d  = res_q;
    idx_d  = idx_q;
    top_d  = top_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (accept) begin
      word_d = wr_data_i;
      top_d  = hit_top;
      idx_d  = '0;
      busy_d = 1'b1;
      res_d  = '0;
    end else if (busy_q) begin
      if (stop) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        res_d[idx_q*ENTRY_W +: ENTRY_W] = evict_i;
        if (last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + FIDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      top_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      word_q <= word_d;
      res_q  <= res_d;
      idx_q  <= idx_d;
      top_q  <= top_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign top_o    = top_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stop && !last) |=> busy_q);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q ##1 !done_q));

  // R9
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stop) |=> (done_q && $stable(res_q)));
endmodule

// File: rtl/kcfg_deque.sv
module kcfg_deque
  import kcfg_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          DEPTH    = 16,
  parameter int          ENTRY_W  = 16,
  parameter int          KEY_W    = 5,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] TOP_ADDR = 12'h4c0,
  parameter logic [11:0] BOT_ADDR = 12'h4c1,
  localparam int         CNT_W    = $clog2(DEPTH + 1),
  localparam int         IDX_W    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [XLEN-1:0]            wr_data_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [XLEN-1:0]            result_o,
  output logic [DEPTH*ENTRY_W-1:0]   entries_o,
  output logic [CNT_W-1:0]           count_o,
  output logic                       full_o
);
  logic                          rst_s1_q, rst_s2_q;
  logic                          rst_sync_n;
  logic                          apply, top_sel, hit;
  logic [ENTRY_W-1:0]            field, evict;
  logic [IDX_W-1:0]              hit_idx;
  logic [DEPTH-1:0][ENTRY_W-1:0] ent;
  logic [CNT_W-1:0]              cnt;
  kcfg_op_e                      op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_sync_n = rst_s2_q;

  kcfg_seq #(
    .XLEN(XLEN), .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W),
    .TOP_ADDR(TOP_ADDR), .BOT_ADDR(BOT_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .evict_i(evict), .apply_o(apply), .top_o(top_sel), .field_o(field),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  kcfg_match #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .KEY_W(KEY_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_match (
    .clk(clk), .rst_n(rst_sync_n),
    .ent_i(ent), .cnt_i(cnt), .key_i(field[KEY_W-1:0]),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  always_comb begin
    if (!apply)              op = OP_IDLE;
    else if (hit)            op = OP_UPDATE;
    else if (field == '0)    op = top_sel ? OP_POP_TOP : OP_POP_BOT;
    else                     op = top_sel ? OP_PUSH_TOP : OP_PUSH_BOT;
  end

  kcfg_store #(
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .op_i(op), .field_i(field), .hit_idx_i(hit_idx),
    .ent_o(ent), .cnt_o(cnt), .full_o(full_o), .evict_o(evict)
  );

  assign entries_o = ent;
  assign count_o   = cnt;

  // R11
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full_o == (count_o == CNT_W'(DEPTH)));

  // R2
  update_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == OP_UPDATE) |-> (evict == '0));
endmodule

// File: tb/kcfg_deque_tb.sv
`timescale 1ns/1ps
module kcfg_deque_tb;
  localparam int XLEN = 64;
  localparam int NF   = XLEN / 16;
  localparam logic [11:0] A_TOP = 12'h4c0;
  localparam logic [11:0] A_BOT = 12'h4c1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [11:0]     wr_addr;
  logic [XLEN-1:0] wr_data;
  logic            busy, done, full;
  logic [XLEN-1:0] result;
  logic [255:0]    entries;
  logic [4:0]      count;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m [16];
  int          mc;
  logic [XLEN-1:0] exp_res;
  int          exp_steps;

  always #10 clk = ~clk;

  kcfg_deque u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_o(busy), .done_o(done), .result_o(result),
    .entries_o(entries), .count_o(count), .full_o(full)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_field(input logic [15:0] f, input bit top, output logic [15:0] ev);
    int hit;
    ev  = '0;
    hit = -1;
    for (int i = 0; i < mc; i++)
      if (hit < 0 && f[4:0] != 5'd0 && m[i][4:0] == f[4:0]) hit = i;
    if (hit >= 0) begin
      m[hit] = f;
    end else if (f == 16'd0) begin
      if (top) begin
        if (mc > 0) begin ev = m[mc-1]; m[mc-1] = '0; mc--; end
      end else begin
        ev = m[0];
        for (int i = 0; i < 15; i++) m[i] = m[i+1];
        m[15] = '0;
        if (mc > 0) mc--;
      end
    end else if (top) begin
      if (mc == 16) begin
        ev = m[0];
        for (int i = 0; i < 15; i++) m[i] = m[i+1];
        m[15] = f;
      end else begin
        m[mc] = f; mc++;
      end
    end else begin
      if (mc == 16) ev = m[15]; else mc++;
      for (int i = 15; i > 0; i--) m[i] = m[i-1];
      m[0] = f;
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [XLEN-1:0] d);
    logic [15:0] ev;
    bit top;
    exp_res   = '0;
    exp_steps = 0;
    top = (a == A_TOP);
    for (int f = 0; f < NF; f++) begin
      exp_steps++;
      if (f > 0 && d[16*f +: 16] == 16'd0) break;
      model_field(d[16*f +: 16], top, ev);
      exp_res[16*f +: 16] = ev;
    end
  endtask

  function automatic logic [255:0] model_flat();
    logic [255:0] v;
    for (int i = 0; i < 16; i++) v[16*i +: 16] = m[i];
    return v;
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " entries"}, entries, model_flat());
    chk("R11 count", 256'(count), 256'(mc));
    chk("R11 full", 256'(full), 256'(mc == 16));
  endtask

  task automatic do_write(input logic [11:0] a, input logic [XLEN-1:0] d, input string tag);
    int waited;
    bit valid;
    valid = (a == A_TOP) || (a == A_BOT);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!valid) begin
      chk("R8 busy stays low", 256'(busy), 256'(0));
      repeat (NF + 1) @(negedge clk);
      chk("R8 no done", 256'(done), 256'(0));
      check_state("R8");
      return;
    end
    chk("R10 busy after accept", 256'(busy), 256'(1));
    model_write(a, d);
    waited = 0;
    while (!done && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk("R10 latency", 256'(waited), 256'(exp_steps));
    chk("R10 busy low at done", 256'(busy), 256'(0));
    chk({tag, " result"}, 256'(result), 256'(exp_res));
    check_state(tag);
  endtask

  function automatic logic [15:0] mk(input int k);
    return {3'b101, 8'(k * 7 + 3), 5'(k)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] d;
    void'($urandom(32'd7351));
    for (int i = 0; i < 16; i++) m[i] = '0;
    mc = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 entries", entries, '0);
    chk("R1 count", 256'(count), 256'(0));
    chk("R1 busy", 256'(busy), 256'(0));
    chk("R1 full", 256'(full), 256'(0));

    do_write(A_TOP, 64'h0101, "R5");
    do_write(A_TOP, 64'h0303_0202, "R5");
    do_write(A_TOP, 64'h0A02, "R2");
    chk("R2 update index", 256'(entries[31:16]), 256'(16'h0A02));
    do_write(A_BOT, 64'h0404, "R7");
    chk("R7 bottom slot", 256'(entries[15:0]), 256'(16'h0404));
    do_write(A_TOP, 64'h0, "R3");
    do_write(A_BOT, 64'h0, "R4");
    do_write(A_TOP, 64'h0, "R3");
    do_write(A_TOP, 64'h0, "R3");
    do_write(A_TOP, 64'h0, "R3 empty pop");
    // R9 later field repeats key of earlier push: update, not push
    do_write(A_BOT, 64'h0000_0000_7705_1105, "R9");
    do_write(A_TOP, 64'h0, "R3");
    // fill to full
    for (int w = 0; w < 4; w++)
      do_write(A_TOP, {mk(4*w+4), mk(4*w+3), mk(4*w+2), mk(4*w+1)}, "R5");
    chk("R11 full reached", 256'(full), 256'(1));
    do_write(A_TOP, 64'(mk(20)), "R6");
    do_write(A_BOT, 64'(mk(21)), "R7 full");
    // key match on a full set: update wins, no eviction
    do_write(A_TOP, 64'({8'hEE, 3'b000, 5'd10}), "R2 full");
    do_write(A_BOT, 64'({8'hDD, 3'b000, 5'd21}), "R2 full");
    do_write(12'h4c2, 64'h0, "R8");
    do_write(12'h000, 64'(mk(9)), "R8");
    do_write(A_BOT, 64'h0, "R4");
    // R10 write while busy is ignored
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_TOP; wr_data = {mk(25), mk(26), mk(27), mk(28)};
    @(negedge clk);
    model_write(A_TOP, wr_data);
    wr_addr = A_TOP; wr_data = 64'h0; // pop attempt during busy
    @(negedge clk);
    wr_en = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 busy write ignored result", 256'(result), 256'(exp_res));
    check_state("R10");
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      int r;
      r = $urandom_range(0, 19);
      a = (r == 0) ? 12'h4c7 : ((r < 10) ? A_TOP : A_BOT);
      for (int f = 0; f < NF; f++) begin
        r = $urandom_range(0, 9);
        if (r < 2)       d[16*f +: 16] = 16'h0;
        else if (r == 2) d[16*f +: 16] = {11'($urandom), 5'd0};
        else             d[16*f +: 16] = {11'($urandom), 5'($urandom_range(1, 7))};
      end
      do_write(a, d, "R9 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule